// File: doc/BRIEF.md
# Sticky Maskable Interrupt Status Unit

This unit gathers event flags from several functional sections of a chip into a set of status registers. Each status register has a companion mask register. A status bit is set as soon as its event input is seen high, whether or not the bit is masked. The mask decides only whether a bit may pull the shared active-low interrupt line. Software clears a bit by reading its register. The bit clears only if its event input is low in the cycle of that read. A bit whose condition is still present stays set, but the read acknowledges it and it no longer holds the interrupt line.

A small register bus (address, read strobe, write strobe, write data, read data) stands in for the serial control port. Read data is registered and appears one cycle after the read strobe. The value returned is the register contents before any clearing caused by that read. By default there are three groups of eight bits each: audio events, monitor events and LED/boost events. Event bit `b` of group `g` enters on `ev_i[g*GRP_W + b]`.

Top module: `irq_status_unit`

## Requirements
- R1: An event input that is high for one sampled clock edge sets its status bit. The bit is readable afterwards whatever the state of its mask bit.
- R2: A status bit whose mask bit is 1 (masked) never drives `irq_n_o` low.
- R3: An event on an unmasked bit drives `irq_n_o` low on the clock edge that samples the event.
- R4: On a read of a status register, each bit whose event input is low in the read cycle clears. Each bit whose event input is still high stays set.
- R5: A read returns, one cycle after the strobe, the register value before the read took effect. A read of a status register withdraws that register's bits from the interrupt, even when their conditions are still present.
- R6: `irq_n_o` stays low until every set, unmasked and not yet read status bit, in every group, has been read.
- R7: After reset all status bits are 0, all mask bits are 1 and `irq_n_o` is high.
- R8: Mask registers are written and read back at address MASK_BASE+g, where MASK_BASE is NUM_GRP rounded up to a power of two (4 by default). Clearing the mask bit of a set, unread status bit drives `irq_n_o` low.
- R9: A write to a status address (address g, below NUM_GRP) changes nothing.
- R10: An event sampled in the same cycle as a read of its register is kept. The read returns the old value, and the bit is set and unread afterwards.
- R11: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | NUM_GRP*GRP_W | Event levels; group g bit b at g*GRP_W+b |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | GRP_W | Write data |
| rdata_o | output | GRP_W | Registered read data, valid the cycle after the strobe |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The embedded assertions check several properties on every cycle: a sampled event always lands in its status bit, and a status bit survives any cycle without a read of its register. They also check that the unread-marker never sits on a cleared status bit, that a mask changes only on its own write, and that unmapped reads return zero. Other behaviours appear only in the bench's scenarios. These are the interplay of reading with a condition still held high, the release of the interrupt across several groups, unmasking a pending bit, an event arriving in the very cycle of its read, and writes aimed at status addresses.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_MASK   = 2'd2
    } acc_kind_e;

    // Mask registers start at the next power of two above the status block.
    function automatic int unsigned mask_base(input int unsigned n_grp);
        return 32'd1 << $clog2(n_grp);
    endfunction

endpackage

// File: rtl/isr_decode.sv
module isr_decode
    import isr_pkg::*;
#(
    parameter int NUM_GRP = 3,
    parameter int ADDR_W  = 3,
    parameter int IDX_W   = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int unsigned BASE = mask_base(NUM_GRP);

    always_comb begin
        int unsigned a;
        a      = 32'(addr_i);
        kind_o = ACC_NONE;
        idx_o  = '0;
        if (a < NUM_GRP) begin
            kind_o = ACC_STATUS;
            idx_o  = IDX_W'(a);
        end else if (a >= BASE && a < BASE + NUM_GRP) begin
            kind_o = ACC_MASK;
            idx_o  = IDX_W'(a - BASE);
        end
    end

endmodule

// File: rtl/isr_group.sv
module isr_group #(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] ev_i,
    input  logic             rd_hit_i,
    input  logic             wr_mask_i,
    input  logic [GRP_W-1:0] wdata_i,
    output logic [GRP_W-1:0] status_o,
    output logic [GRP_W-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [GRP_W-1:0] status;
        logic [GRP_W-1:0] pend;
        logic [GRP_W-1:0] mask;
        logic [GRP_W-1:0] ev_q;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        logic [GRP_W-1:0] new_evt;
        logic [GRP_W-1:0] clr;
        st_d    = st_q;
        new_evt = ev_i & ~st_q.ev_q;
        clr     = rd_hit_i ? ~ev_i : '0;
        st_d.ev_q   = ev_i;
        st_d.status = (st_q.status & ~clr) | ev_i;
        st_d.pend   = (rd_hit_i ? '0 : st_q.pend) | new_evt;
        if (wr_mask_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.pend   <= '0;
            st_q.mask   <= '1;
            st_q.ev_q   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.pend & ~st_q.mask);

    // R1: a sampled event always shows up in status
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((st_q.status & $past(ev_i)) == $past(ev_i)));

    // R4: without a read nothing clears
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit_i |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));

    // R5: an unread marker only exists on a set status bit
    a_r5_pend_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & ~st_q.status) == '0));

    // R6: unread markers persist until a read
    a_r6_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit_i |=> (($past(st_q.pend) & ~st_q.pend) == '0));

    // R8: mask changes only on its own write
    a_r8_mask_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_i |=> $stable(st_q.mask));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isr_pkg::*;
#(
    parameter int NUM_GRP = 3,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = $clog2(mask_base(NUM_GRP) + NUM_GRP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_GRP*GRP_W-1:0] ev_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     rd_en_i,
    input  logic                     wr_en_i,
    input  logic [GRP_W-1:0]         wdata_i,
    output logic [GRP_W-1:0]         rdata_o,
    output logic                     irq_n_o
);

    localparam int IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [GRP_W-1:0] stat_a [NUM_GRP];
    logic [GRP_W-1:0] mask_a [NUM_GRP];
    logic [NUM_GRP-1:0] irq_v;
    logic [NUM_GRP-1:0] rd_hit;
    logic [NUM_GRP-1:0] wr_mask;
    logic [GRP_W-1:0] rdata_d, rdata_q;

    isr_decode #(
        .NUM_GRP (NUM_GRP),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_dec (
        .addr_i (addr_i),
        .kind_o (kind),
        .idx_o  (idx)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign rd_hit[g]  = rd_en_i && (kind == ACC_STATUS) && (idx == IDX_W'(g));
        assign wr_mask[g] = wr_en_i && (kind == ACC_MASK) && (idx == IDX_W'(g));

        isr_group #(.GRP_W(GRP_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_i      (ev_i[g*GRP_W +: GRP_W]),
            .rd_hit_i  (rd_hit[g]),
            .wr_mask_i (wr_mask[g]),
            .wdata_i   (wdata_i),
            .status_o  (stat_a[g]),
            .mask_o    (mask_a[g]),
            .irq_o     (irq_v[g])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            unique case (kind)
                ACC_STATUS: rdata_d = stat_a[idx];
                ACC_MASK:   rdata_d = mask_a[idx];
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;
    assign irq_n_o = ~|irq_v;

    // R11: unmapped addresses read as zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && kind == ACC_NONE) |=> (rdata_o == '0));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int NG = 3;
    localparam int GW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*GW-1:0] ev = '0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [GW-1:0] wdata = '0;
    logic [GW-1:0] rdata;
    logic          irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [GW-1:0] exp_q [$];
    string         tag_q [$];

    always #10 clk = ~clk;

    irq_status_unit #(.NUM_GRP(NG), .GRP_W(GW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .addr_i  (addr),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_n_o (irq_n)
    );

    task automatic check(input string tag, input logic [GW-1:0] got, input logic [GW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_irq(input string tag, input logic exp);
        check(tag, {7'd0, irq_n}, {7'd0, exp});
    endtask

    // Monitor: read data appears the cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [GW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [GW-1:0] exp, input string tag);
        addr  = a;
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [GW-1:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int bitpos);
        ev[bitpos] = 1'b1;
        @(negedge clk);
        ev[bitpos] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        check_irq("R7 irq after reset", 1'b1);
        rd(3'd0, 8'h00, "R7 status0 reset");
        rd(3'd4, 8'hFF, "R7 mask0 reset");
        rd(3'd6, 8'hFF, "R7 mask2 reset");

        // R1/R2 masked event
        pulse(0);
        check_irq("R2 masked event no irq", 1'b1);
        rd(3'd0, 8'h01, "R1 masked event visible");
        rd(3'd0, 8'h00, "R4 cleared by read");

        // R3/R5 unmasked event
        wr(3'd5, 8'h00);
        pulse(8 + 3);
        check_irq("R3 unmasked event irq", 1'b0);
        rd(3'd1, 8'h08, "R5 read returns value");
        check_irq("R5 irq released by read", 1'b1);
        rd(3'd1, 8'h00, "R4 cleared after read");

        // R4/R5 held condition
        ev[10] = 1'b1;
        @(negedge clk);
        check_irq("R3 held event irq", 1'b0);
        rd(3'd1, 8'h04, "R4 held read1");
        check_irq("R5 irq released while held", 1'b1);
        rd(3'd1, 8'h04, "R4 held bit stays");
        ev[10] = 1'b0;
        @(negedge clk);
        rd(3'd1, 8'h04, "R4 still set until read");
        rd(3'd1, 8'h00, "R4 cleared after drop");
        check_irq("R4 irq idle", 1'b1);

        // R6 two groups
        wr(3'd6, 8'hFD);
        pulse(8);
        pulse(16 + 1);
        check_irq("R6 two pending irq", 1'b0);
        rd(3'd1, 8'h01, "R6 group1 read");
        check_irq("R6 irq kept for group2", 1'b0);
        rd(3'd2, 8'h02, "R6 group2 read");
        check_irq("R6 irq released", 1'b1);

        // R8 unmask pending bit
        pulse(5);
        check_irq("R2 masked g0b5", 1'b1);
        wr(3'd4, 8'hDF);
        check_irq("R8 unmask asserts irq", 1'b0);
        rd(3'd4, 8'hDF, "R8 mask readback");
        rd(3'd0, 8'h20, "R8 status0 read");
        check_irq("R8 irq released", 1'b1);

        // R9 writes to status addresses
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'hFF);
        rd(3'd0, 8'h00, "R9 status0 unchanged");
        rd(3'd2, 8'h00, "R9 status2 unchanged");
        check_irq("R9 no irq", 1'b1);

        // R11 unmapped
        rd(3'd3, 8'h00, "R11 addr3 zero");
        rd(3'd7, 8'h00, "R11 addr7 zero");

        // R10 event coincident with read
        ev[15] = 1'b1;
        addr   = 3'd1;
        rd_en  = 1'b1;
        exp_q.push_back(8'h00);
        tag_q.push_back("R10 read returns old");
        @(negedge clk);
        ev[15] = 1'b0;
        rd_en  = 1'b0;
        @(negedge clk);
        check_irq("R10 event kept unread", 1'b0);
        rd(3'd1, 8'h80, "R10 bit kept");
        check_irq("R10 irq released", 1'b1);

        // R2 multi-bit masked pattern
        ev[23:16] = 8'hA5;
        @(negedge clk);
        ev[23:16] = 8'h00;
        @(negedge clk);
        check_irq("R2 masked pattern no irq", 1'b1);
        rd(3'd2, 8'hA5, "R1 multi-bit pattern");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule